// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a physical one. A logical address is given as a segment number and an offset within that segment. The unit keeps a small table store that holds one segment table per process. A table-select register, loaded by the surrounding system, names the table of the process that is running. The segment number picks a row in that table. Each row has a presence flag, a physical base and a segment length.

For every request the unit reads the selected row. It checks presence first and the offset bound second. If both checks pass it returns base plus offset. If a check fails it returns a fault code and a zero address. To switch process, the system only reloads the table-select register. Software keeps the tables current through a write port. That port also clears a row's presence flag when its segment is moved out to backing storage. Requests use a valid/ready handshake, only one request is in flight at a time, and every request takes two cycles.

Top module: `seg_xlate`

## Requirements
- R1: After reset, no response is valid, `req_ready` is high, the table select is 0 and every row of every table is absent, so a request returns fault code 01.
- R2: A request accepted in cycle c (valid and ready both high) gives `rsp_valid` in cycle c+2. `req_ready` stays low from the accept until the response has been taken.
- R3: The row used is the one at the table-select value and the segment number. If that row is present and the offset is below its length, the response has fault code 00 and the address base + offset, truncated to 16 bits.
- R4: If the selected row is absent, the response has fault code 01 and address 0, whatever the row's length.
- R5: If the row is present and the offset is greater than or equal to its length, the response has fault code 10 and address 0. Offset = length-1 is in bounds, and a length of 0 faults for every offset. Code 11 is never produced.
- R6: A table-select load applies to requests accepted in later cycles. A request accepted in the same cycle as the load still uses the previous table.
- R7: The write port can set any row of any table, including the row at the highest index. A write in the same cycle as an accept, to the row that request reads, is not seen by that request but is seen by the next one.
- R8: Rewriting a row with its presence flag cleared makes later requests to it return fault code 01.
- R9: While `rsp_ready` is low, `rsp_valid`, `rsp_addr` and `rsp_fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load a new table-select value |
| ctx_value | input | 2 | Table index of the process to run |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_seg | input | 4 | Segment number |
| req_off | input | 12 | Offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 absent, 10 out of bounds |
| tw_en | input | 1 | Table row write strobe |
| tw_table | input | 2 | Table to write |
| tw_seg | input | 4 | Row within that table |
| tw_present | input | 1 | New presence flag |
| tw_base | input | 16 | New physical base |
| tw_len | input | 12 | New segment length |

## Verification
The assertions assume that every input is a known value whenever its strobe (`req_valid`, `tw_en`, `ctx_load`) is high. They also assume that the consumer's `rsp_ready` is the only thing that can stall a response. The bench changes all inputs only on the falling clock edge and holds them steady through the next rising edge. It raises `req_valid` only while the unit is idle, and it keeps `tw_en` and `ctx_load` high for one cycle per write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_BOUND  = 2'b10
  } fault_e;
endpackage

// File: rtl/seg_ctx_reg.sv
module seg_ctx_reg #(
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TID_W-1:0] value,
  output logic [TID_W-1:0] ctx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ctx <= '0;
    else if (load) ctx <= value;
  end
endmodule

// File: rtl/seg_table_mem.sv
module seg_table_mem #(
  parameter int IDX_W   = 6,
  parameter int ENTRY_W = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)                         rows[i] <= '0;
      else if (we && waddr == IDX_W'(i))  rows[i] <= wdata;
    end
  end

  assign rdata = rows[raddr];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int LEN_W  = 12,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 16
) (
  input  logic              present,
  input  logic [BASE_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [OFF_W-1:0]  off,
  output logic              bound_ok,
  output logic [PA_W-1:0]   pa,
  output fault_e            fault
);
  localparam int CMP_W = (OFF_W > LEN_W) ? OFF_W : LEN_W;

  function automatic logic [PA_W-1:0] add_wrap(input logic [BASE_W-1:0] b,
                                               input logic [OFF_W-1:0]  o);
    return PA_W'(b) + PA_W'(o);
  endfunction

  function automatic logic below(input logic [OFF_W-1:0] o,
                                 input logic [LEN_W-1:0] l);
    return CMP_W'(o) < CMP_W'(l);
  endfunction

  assign bound_ok = below(off, len);

  always_comb begin
    if (!present) begin
      fault = FLT_ABSENT;
      pa    = '0;
    end else if (!bound_ok) begin
      fault = FLT_BOUND;
      pa    = '0;
    end else begin
      fault = FLT_NONE;
      pa    = add_wrap(base, off);
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_TABLES = 4,
  parameter int SEGS       = 16,
  parameter int OFF_W      = 12,
  parameter int BASE_W     = 16,
  parameter int LEN_W      = 12,
  parameter int PA_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctx_load,
  input  logic [$clog2(NUM_TABLES)-1:0] ctx_value,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(SEGS)-1:0]       req_seg,
  input  logic [OFF_W-1:0]              req_off,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [PA_W-1:0]               rsp_addr,
  output logic [1:0]                    rsp_fault,
  input  logic                          tw_en,
  input  logic [$clog2(NUM_TABLES)-1:0] tw_table,
  input  logic [$clog2(SEGS)-1:0]       tw_seg,
  input  logic                          tw_present,
  input  logic [BASE_W-1:0]             tw_base,
  input  logic [LEN_W-1:0]              tw_len
);
  localparam int TID_W   = $clog2(NUM_TABLES);
  localparam int SEG_W   = $clog2(SEGS);
  localparam int IDX_W   = TID_W + SEG_W;
  localparam int ENTRY_W = 1 + BASE_W + LEN_W;

  logic [TID_W-1:0]   ctx;
  logic [ENTRY_W-1:0] rd_row;
  logic               accept;

  logic               s1_valid;
  logic [ENTRY_W-1:0] s1_row;
  logic [OFF_W-1:0]   s1_off;

  logic               row_present;
  logic [BASE_W-1:0]  row_base;
  logic [LEN_W-1:0]   row_len;
  logic               bound_ok;
  logic [PA_W-1:0]    chk_pa;
  fault_e             chk_fault;

  seg_ctx_reg #(.TID_W(TID_W)) u_ctx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctx_load),
    .value (ctx_value),
    .ctx   (ctx)
  );

  seg_table_mem #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tw_en),
    .waddr ({tw_table, tw_seg}),
    .wdata ({tw_present, tw_base, tw_len}),
    .raddr ({ctx, req_seg}),
    .rdata (rd_row)
  );

  assign req_ready = !s1_valid && !rsp_valid;
  assign accept    = req_valid && req_ready;

  // Stage 1: snapshot of the row; a same-edge write lands after the snapshot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_row   <= '0;
      s1_off   <= '0;
    end else if (accept) begin
      s1_valid <= 1'b1;
      s1_row   <= rd_row;
      s1_off   <= req_off;
    end else begin
      s1_valid <= 1'b0;
    end
  end

  assign {row_present, row_base, row_len} = s1_row;

  seg_check #(.BASE_W(BASE_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .present  (row_present),
    .base     (row_base),
    .len      (row_len),
    .off      (s1_off),
    .bound_ok (bound_ok),
    .pa       (chk_pa),
    .fault    (chk_fault)
  );

  // Stage 2: response register, held until taken.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= FLT_NONE;
    end else if (s1_valid) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= chk_pa;
      rsp_fault <= chk_fault;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            req_ready,
  input logic            s1_valid,
  input logic            row_present,
  input logic            bound_ok,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_addr,
  input logic [1:0]      rsp_fault
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 rsp_valid);

  a_r2_single_stage: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> !req_ready);

  a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r3_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && row_present && bound_ok) |=> (rsp_valid && rsp_fault == 2'b00));

  a_r4_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b01) |-> rsp_addr == '0);

  a_r5_bound_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b10) |-> rsp_addr == '0);

  a_r5_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_xlate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_ready   (req_ready),
  .s1_valid    (s1_valid),
  .row_present (row_present),
  .bound_ok    (bound_ok),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_addr    (rsp_addr),
  .rsp_fault   (rsp_fault)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_load = 1'b0;
  logic [1:0]  ctx_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [11:0] req_off = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_addr;
  logic [1:0]  rsp_fault;
  logic        tw_en = 1'b0;
  logic [1:0]  tw_table = '0;
  logic [3:0]  tw_seg = '0;
  logic        tw_present = 1'b0;
  logic [15:0] tw_base = '0;
  logic [11:0] tw_len = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_value(ctx_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .tw_en(tw_en), .tw_table(tw_table), .tw_seg(tw_seg), .tw_present(tw_present),
    .tw_base(tw_base), .tw_len(tw_len)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit m_pres [4][16];
  int m_base [4][16];
  int m_len  [4][16];
  int m_ctx;
  int m_stage;
  int m_addr;
  int m_fault;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctx = 0; m_stage = 0; m_addr = 0; m_fault = 0;
      foreach (m_pres[t, s]) begin
        m_pres[t][s] = 1'b0; m_base[t][s] = 0; m_len[t][s] = 0;
      end
    end else begin
      if (m_stage == 2) begin
        if (rsp_ready) m_stage = 0;
      end else if (m_stage == 1) begin
        m_stage = 2;
      end else if (req_valid) begin
        if (!m_pres[m_ctx][req_seg]) begin
          m_addr = 0; m_fault = 1;
        end else if (int'(req_off) >= m_len[m_ctx][req_seg]) begin
          m_addr = 0; m_fault = 2;
        end else begin
          m_addr = (m_base[m_ctx][req_seg] + int'(req_off)) % 65536; m_fault = 0;
        end
        m_stage = 1;
      end
      if (tw_en) begin
        m_pres[tw_table][tw_seg] = tw_present;
        m_base[tw_table][tw_seg] = int'(tw_base);
        m_len[tw_table][tw_seg]  = int'(tw_len);
      end
      if (ctx_load) m_ctx = int'(ctx_value);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_ready == (m_stage == 0), "R2", "model req_ready", req_ready, m_stage == 0);
      check(rsp_valid == (m_stage == 2), "R2", "model rsp_valid", rsp_valid, m_stage == 2);
      if (m_stage == 2) begin
        check(rsp_addr == m_addr[15:0], "R3", "model rsp_addr", rsp_addr, m_addr);
        check(rsp_fault == m_fault[1:0], "R4", "model rsp_fault", rsp_fault, m_fault);
      end
    end
  end

  // Called at a falling edge with the unit idle; returns at a falling edge, idle again.
  task automatic xlate(input logic [3:0] seg, input logic [11:0] off,
                       input int exp_addr, input int exp_fault, input string tag);
    req_seg = seg; req_off = off; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R2", "rsp_valid one cycle after accept", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R2", "rsp_valid two cycles after accept", rsp_valid, 1);
    check(rsp_addr == exp_addr[15:0], tag, "rsp_addr", rsp_addr, exp_addr);
    check(rsp_fault == exp_fault[1:0], tag, "rsp_fault", rsp_fault, exp_fault);
    @(negedge clk);
  endtask

  task automatic wr_row(input logic [1:0] tbl, input logic [3:0] seg, input logic pres,
                        input logic [15:0] base, input logic [11:0] len);
    tw_en = 1'b1; tw_table = tbl; tw_seg = seg;
    tw_present = pres; tw_base = base; tw_len = len;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic set_ctx(input logic [1:0] v);
    ctx_load = 1'b1; ctx_value = v;
    @(negedge clk);
    ctx_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    xlate(4'd0, 12'h000, 0, 1, "R1");
    xlate(4'd15, 12'h7FF, 0, 1, "R1");

    wr_row(2'd0, 4'd3, 1'b1, 16'h1000, 12'h100);
    wr_row(2'd0, 4'd5, 1'b1, 16'hFF00, 12'h300);
    wr_row(2'd0, 4'd7, 1'b0, 16'h2000, 12'hFFF);
    wr_row(2'd0, 4'd9, 1'b1, 16'h5000, 12'h000);
    wr_row(2'd2, 4'd3, 1'b1, 16'h4000, 12'h800);
    wr_row(2'd3, 4'd15, 1'b1, 16'hABCD, 12'hFFF);

    // R3: in-bounds translation, including wrap of the 16-bit sum
    xlate(4'd3, 12'h000, 16'h1000, 0, "R3");
    xlate(4'd3, 12'h0FF, 16'h10FF, 0, "R3");
    xlate(4'd5, 12'h200, 16'h0100, 0, "R3");
    // R4: absent row with a large length still faults
    xlate(4'd7, 12'h001, 0, 1, "R4");
    // R5: bound faults and edges
    xlate(4'd3, 12'h100, 0, 2, "R5");
    xlate(4'd9, 12'h000, 0, 2, "R5");

    // R6: table switch
    set_ctx(2'd2);
    xlate(4'd3, 12'h7FF, 16'h47FF, 0, "R6");
    xlate(4'd3, 12'h800, 0, 2, "R6");
    ctx_load = 1'b1; ctx_value = 2'd0;
    req_seg = 4'd3; req_off = 12'h010; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    ctx_load = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check(rsp_addr == 16'h4010, "R6", "same-cycle load uses old table", rsp_addr, 16'h4010);
    @(negedge clk);
    xlate(4'd3, 12'h010, 16'h1010, 0, "R6");

    // R7: write in the accept cycle is seen only by the next request
    tw_en = 1'b1; tw_table = 2'd0; tw_seg = 4'd3;
    tw_present = 1'b1; tw_base = 16'h3000; tw_len = 12'h100;
    req_seg = 4'd3; req_off = 12'h020; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    tw_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check(rsp_addr == 16'h1020, "R7", "same-cycle write not seen", rsp_addr, 16'h1020);
    @(negedge clk);
    xlate(4'd3, 12'h020, 16'h3020, 0, "R7");
    // R7: highest row of the highest table, last in-bounds offset and first beyond
    set_ctx(2'd3);
    xlate(4'd15, 12'hFFE, 16'hBBCB, 0, "R7");
    xlate(4'd15, 12'hFFF, 0, 2, "R5");
    set_ctx(2'd0);

    // R8: swap-out clears presence
    wr_row(2'd0, 4'd3, 1'b0, 16'h3000, 12'h100);
    xlate(4'd3, 12'h020, 0, 1, "R8");

    // R9: response holds while stalled
    rsp_ready = 1'b0;
    req_seg = 4'd5; req_off = 12'h010; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R9", "rsp_valid held", rsp_valid, 1);
      check(rsp_addr == 16'hFF10, "R9", "rsp_addr held", rsp_addr, 16'hFF10);
      check(rsp_fault == 2'b00, "R9", "rsp_fault held", rsp_fault, 0);
      check(req_ready == 1'b0, "R2", "req_ready low while stalled", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "response taken", rsp_valid, 0);
    check(req_ready == 1'b1, "R2", "ready after take", req_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule